// File: doc/BRIEF.md
# Chained Descriptor DMA Walker

This block is the internal data mover of a card host controller. Software builds a list of four-word descriptors in system memory, writes the address of the first one into a base register and enables the engine. The engine then reads each descriptor and checks that the descriptor is handed over to it. It moves the buffer the descriptor names between memory and the card data FIFO, returns the descriptor to software by rewriting its flags word with the ownership bit cleared, and moves on to the next descriptor until it reaches one marked as the last segment.

Each descriptor holds, at byte offsets 0, 4, 8 and 12, a flags word, a byte count, a buffer address and a next-descriptor address. The engine has a single-beat memory master with a request/acknowledge handshake, a push port towards the transmit side of the FIFO, a pop port from its receive side, and a small word-addressed register port for control, bus mode, base address and status.

Top module: `dd_chain_dma`

## Requirements
- R1: A walk starts by reading four words at the base address, base+4, base+8 and base+12, in that order, and interprets them as flags, byte count, buffer address and next-descriptor address.
- R2: Register index 0 is control, 1 is bus mode, 2 is base address, 3 is status. A write to the base register arms the engine. An armed engine leaves idle only while control bit 5, control bit 25 and bus-mode bit 7 are all set. Any one of them clear keeps the memory master silent.
- R3: If the flags word fetched has bit 31 (ownership) clear, the engine makes no further memory access, moves no data, and sets status bit 1.
- R4: A descriptor moves ceil(count/4) 32-bit words. On transmit (control bit 10 set) the words are read from consecutive addresses starting at the buffer address and pushed to the FIFO in order. On receive they are popped and written to those addresses. A count of zero moves nothing.
- R5: The engine never pushes while the FIFO reports full and never pops while it reports empty. It waits in place and resumes when the condition clears.
- R6: After a descriptor's data, the engine writes its flags word back to the descriptor address with bit 31 cleared and every other bit kept, before any read of the next descriptor.
- R7: With flags bit 4 set the next descriptor is at the stored next-descriptor address. With bit 4 clear it is at the current descriptor address plus 16, and the stored pointer is ignored.
- R8: After writing back a descriptor whose flags bit 2 (last segment) is set, the engine returns to idle and sets status bit 0.
- R9: Control bits 0, 1 and 2 read back as 1 for exactly one cycle after being written and then clear themselves. Bit 1 drives the FIFO flush output while set. Bit 0 clears every register. Bit 2, and bus-mode bit 0, abort a walk in progress with no further memory access and no status bit set.
- R10: Status bits are write-one-to-clear. All registers read zero after reset.
- R11: Once raised, a memory request keeps its address, direction and write data until the cycle it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge, completes the request |
| fifo_push | output | 1 | Push a word to the transmit FIFO |
| fifo_wdata | output | 32 | Word pushed |
| fifo_full | input | 1 | Transmit FIFO full |
| fifo_pop | output | 1 | Pop a word from the receive FIFO |
| fifo_rdata | input | 32 | Head word of the receive FIFO, valid while not empty |
| fifo_empty | input | 1 | Receive FIFO empty |
| fifo_flush | output | 1 | FIFO flush request |

## Verification
The assertions take for granted that memory raises mem_ack only while mem_req is high, and that fifo_full does not rise while a transmit read is waiting for its acknowledge, since only the engine fills the FIFO. The bench memory acknowledges every request exactly one cycle after it appears. The bench raises its full flag only before a walk starts and only lowers it during a walk. The receive source only grows its available count, so the FIFO flags change only in the directions the engine's own traffic allows.

// File: rtl/dd_pkg.sv
package dd_pkg;

  localparam int WORD_W     = 32;
  localparam int FLAG_OWN   = 31;
  localparam int FLAG_CHAIN = 4;
  localparam int FLAG_FIRST = 3;
  localparam int FLAG_LAST  = 2;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_BMOD = 2'd1;
  localparam logic [1:0] RA_BASE = 2'd2;
  localparam logic [1:0] RA_STAT = 2'd3;

  typedef enum logic [2:0] {
    W_IDLE,
    W_FETCH,
    W_TX,
    W_RXPOP,
    W_RXWR,
    W_WBACK
  } walk_t;

  // number of 32-bit beats for a byte count, rounded up
  function automatic logic [WORD_W-1:0] words_of(input logic [WORD_W-1:0] nbytes);
    return (nbytes + 32'd3) >> 2;
  endfunction

  // address of the descriptor after the current one
  function automatic logic [WORD_W-1:0] next_desc(input logic [WORD_W-1:0] cur,
                                                  input logic [WORD_W-1:0] flags,
                                                  input logic [WORD_W-1:0] nxt);
    return flags[FLAG_CHAIN] ? nxt : cur + 32'd16;
  endfunction

  // flags word handed back to software
  function automatic logic [WORD_W-1:0] wback_word(input logic [WORD_W-1:0] flags);
    return flags & ~(32'h1 << FLAG_OWN);
  endfunction

endpackage

// File: rtl/dd_regs.sv
module dd_regs
  import dd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              start_evt,
  input  logic              done_evt,
  input  logic              unavail_evt,
  output logic              run_ok,
  output logic              dir_tx,
  output logic              armed,
  output logic              abort,
  output logic              fifo_flush,
  output logic [WORD_W-1:0] base_addr
);

  localparam logic [WORD_W-1:0] CTRL_MASK = 32'h0200_0427; // bits 25,10,5,2,1,0
  localparam logic [WORD_W-1:0] BMOD_MASK = 32'h0000_0083; // bits 7,1,0
  localparam logic [WORD_W-1:0] CTRL_SELF = 32'h0000_0007;
  localparam logic [WORD_W-1:0] BMOD_SELF = 32'h0000_0001;

  logic [WORD_W-1:0] ctrl_q, ctrl_n;
  logic [WORD_W-1:0] bmod_q, bmod_n;
  logic [WORD_W-1:0] base_q, base_n;
  logic [1:0]        stat_q, stat_n;
  logic              armed_q, armed_n;
  logic              wr_ctrl, wr_bmod, wr_base, wr_stat;
  logic              ctl_reset;

  assign wr_ctrl   = reg_we && (reg_addr == RA_CTRL);
  assign wr_bmod   = reg_we && (reg_addr == RA_BMOD);
  assign wr_base   = reg_we && (reg_addr == RA_BASE);
  assign wr_stat   = reg_we && (reg_addr == RA_STAT);
  assign ctl_reset = ctrl_q[0];

  always_comb begin
    ctrl_n  = wr_ctrl ? (reg_wdata & CTRL_MASK) : (ctrl_q & ~CTRL_SELF);
    bmod_n  = wr_bmod ? (reg_wdata & BMOD_MASK) : (bmod_q & ~BMOD_SELF);
    base_n  = wr_base ? reg_wdata : base_q;
    stat_n  = stat_q & ~(wr_stat ? reg_wdata[1:0] : 2'b00);
    stat_n  = stat_n | {unavail_evt, done_evt};
    armed_n = armed_q;
    if (start_evt) armed_n = 1'b0;
    if (wr_base)   armed_n = 1'b1;
    if (abort)     armed_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      bmod_q  <= '0;
      base_q  <= '0;
      stat_q  <= '0;
      armed_q <= 1'b0;
    end else if (ctl_reset) begin
      ctrl_q  <= '0;
      bmod_q  <= '0;
      base_q  <= '0;
      stat_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_n;
      bmod_q  <= bmod_n;
      base_q  <= base_n;
      stat_q  <= stat_n;
      armed_q <= armed_n;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = ctrl_q;
      RA_BMOD: reg_rdata = bmod_q;
      RA_BASE: reg_rdata = base_q;
      default: reg_rdata = {30'd0, stat_q};
    endcase
  end

  assign run_ok     = ctrl_q[5] & ctrl_q[25] & bmod_q[7];
  assign dir_tx     = ctrl_q[10];
  assign armed      = armed_q;
  assign abort      = ctrl_q[0] | ctrl_q[2] | bmod_q[0];
  assign fifo_flush = ctrl_q[1];
  assign base_addr  = base_q;

  AST_RESET_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ctrl_q[2:0]) && !wr_ctrl) |=> (ctrl_q[2:0] == 3'b000)); // R9

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[0] && !wr_stat && !ctl_reset) |=> stat_q[0]); // R10

endmodule

// File: rtl/dd_walker.sv
module dd_walker
  import dd_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_ok,
  input  logic              dir_tx,
  input  logic              armed,
  input  logic              abort,
  input  logic [WORD_W-1:0] base_addr,
  output logic              start_evt,
  output logic              done_evt,
  output logic              unavail_evt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              fifo_push,
  output logic [WORD_W-1:0] fifo_wdata,
  input  logic              fifo_full,
  output logic              fifo_pop,
  input  logic [WORD_W-1:0] fifo_rdata,
  input  logic              fifo_empty
);

  localparam int PAD_W = WORD_W - CNT_W;

  walk_t             st;
  logic [WORD_W-1:0] dptr, flg, buf_q, nxt_q, ptr, hold;
  logic [CNT_W-1:0]  cnt_q, left_q;
  logic [1:0]        widx;
  logic [WORD_W-1:0] cnt_words;
  logic              ack_ok, busy, last_beat;

  assign cnt_words = words_of({{PAD_W{1'b0}}, cnt_q});
  assign ack_ok    = mem_req && mem_ack;
  assign busy      = (st != W_IDLE);
  assign last_beat = (left_q == CNT_W'(1));

  assign start_evt   = (st == W_IDLE) && armed && run_ok && !abort;
  assign unavail_evt = (st == W_FETCH) && ack_ok && (widx == 2'd0) && !mem_rdata[FLAG_OWN];
  assign done_evt    = (st == W_WBACK) && ack_ok && flg[FLAG_LAST];

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      W_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = dptr + {28'd0, widx, 2'b00};
      end
      W_TX: begin
        mem_req  = !fifo_full;
        mem_addr = ptr;
      end
      W_RXWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr;
        mem_wdata = hold;
      end
      W_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dptr;
        mem_wdata = wback_word(flg);
      end
      default: ;
    endcase
  end

  assign fifo_push  = (st == W_TX) && ack_ok;
  assign fifo_wdata = mem_rdata;
  assign fifo_pop   = (st == W_RXPOP) && !fifo_empty && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= W_IDLE;
      dptr   <= '0;
      flg    <= '0;
      buf_q  <= '0;
      nxt_q  <= '0;
      ptr    <= '0;
      hold   <= '0;
      cnt_q  <= '0;
      left_q <= '0;
      widx   <= '0;
    end else if (abort) begin
      st <= W_IDLE;
    end else begin
      case (st)
        W_IDLE: if (start_evt) begin
          dptr <= base_addr;
          widx <= 2'd0;
          st   <= W_FETCH;
        end
        W_FETCH: if (ack_ok) begin
          widx <= widx + 2'd1;
          case (widx)
            2'd0: begin
              flg <= mem_rdata;
              if (!mem_rdata[FLAG_OWN]) st <= W_IDLE;
            end
            2'd1: cnt_q <= mem_rdata[CNT_W-1:0];
            2'd2: buf_q <= mem_rdata;
            default: begin
              nxt_q  <= mem_rdata;
              ptr    <= buf_q;
              left_q <= cnt_words[CNT_W-1:0];
              if (cnt_q == '0)  st <= W_WBACK;
              else if (dir_tx)  st <= W_TX;
              else              st <= W_RXPOP;
            end
          endcase
        end
        W_TX: if (ack_ok) begin
          ptr    <= ptr + 32'd4;
          left_q <= left_q - CNT_W'(1);
          if (last_beat) st <= W_WBACK;
        end
        W_RXPOP: if (fifo_pop) begin
          hold <= fifo_rdata;
          st   <= W_RXWR;
        end
        W_RXWR: if (ack_ok) begin
          ptr    <= ptr + 32'd4;
          left_q <= left_q - CNT_W'(1);
          st     <= last_beat ? W_WBACK : W_RXPOP;
        end
        W_WBACK: if (ack_ok) begin
          if (flg[FLAG_LAST]) begin
            st <= W_IDLE;
          end else begin
            dptr <= next_desc(dptr, flg, nxt_q);
            widx <= 2'd0;
            st   <= W_FETCH;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> $past(run_ok)); // R2

  AST_UNAVAIL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    unavail_evt |=> !mem_req); // R3

  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !fifo_full); // R5

  AST_LAST_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !mem_req); // R8

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !abort) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11

endmodule

// File: rtl/dd_chain_dma.sv
module dd_chain_dma
  import dd_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        fifo_push,
  output logic [31:0] fifo_wdata,
  input  logic        fifo_full,
  output logic        fifo_pop,
  input  logic [31:0] fifo_rdata,
  input  logic        fifo_empty,
  output logic        fifo_flush
);

  logic              run_ok, dir_tx, armed, abort;
  logic              start_evt, done_evt, unavail_evt;
  logic [WORD_W-1:0] base_addr;

  dd_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .start_evt   (start_evt),
    .done_evt    (done_evt),
    .unavail_evt (unavail_evt),
    .run_ok      (run_ok),
    .dir_tx      (dir_tx),
    .armed       (armed),
    .abort       (abort),
    .fifo_flush  (fifo_flush),
    .base_addr   (base_addr)
  );

  dd_walker #(.CNT_W(CNT_W)) u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_ok      (run_ok),
    .dir_tx      (dir_tx),
    .armed       (armed),
    .abort       (abort),
    .base_addr   (base_addr),
    .start_evt   (start_evt),
    .done_evt    (done_evt),
    .unavail_evt (unavail_evt),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_ack     (mem_ack),
    .fifo_push   (fifo_push),
    .fifo_wdata  (fifo_wdata),
    .fifo_full   (fifo_full),
    .fifo_pop    (fifo_pop),
    .fifo_rdata  (fifo_rdata),
    .fifo_empty  (fifo_empty)
  );

endmodule

// File: tb/tb_dd_chain_dma.sv
`timescale 1ns/1ps
module tb_dd_chain_dma;

  localparam logic [31:0] OWN  = 32'h8000_0000;
  localparam logic [31:0] CH   = 32'h0000_0010;
  localparam logic [31:0] FS   = 32'h0000_0008;
  localparam logic [31:0] LD   = 32'h0000_0004;
  localparam logic [31:0] RUN  = 32'h0200_0020;
  localparam logic [31:0] TXB  = 32'h0000_0400;

  // {dir, chain, ndesc[2], cnt0[8], cnt1[8], expected words[8]}
  localparam int NVEC = 6;
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 2'd1, 8'd16, 8'd0,  8'd4},
    {1'b1, 1'b1, 2'd2, 8'd12, 8'd20, 8'd8},
    {1'b0, 1'b1, 2'd2, 8'd8,  8'd32, 8'd10},
    {1'b0, 1'b0, 2'd2, 8'd16, 8'd8,  8'd6},
    {1'b1, 1'b0, 2'd2, 8'd6,  8'd4,  8'd3},
    {1'b0, 1'b1, 2'd1, 8'd32, 8'd0,  8'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_ack;
  logic        fifo_push, fifo_pop, fifo_flush;
  logic [31:0] fifo_wdata;
  logic        fifo_full, fifo_empty;
  logic [31:0] fifo_rdata;

  int errors = 0;
  int checks = 0;

  logic [31:0] mem [128];
  logic [31:0] txq [64];
  logic [31:0] rx_src [64];
  int          tx_n, rx_rd, rx_avail, hs_cnt, viol;
  logic        force_full = 1'b0;
  logic        tb_clr = 1'b0;
  logic        prev_pend;
  logic [31:0] prev_addr;
  logic [31:0] f0, f1;
  int          d1w;

  always #2 clk = ~clk;

  dd_chain_dma dut (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_full(fifo_full),
    .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
    .fifo_flush(fifo_flush)
  );

  assign fifo_full  = force_full;
  assign fifo_empty = (rx_rd >= rx_avail);
  assign fifo_rdata = rx_src[rx_rd[5:0]];

  // memory with a one-cycle acknowledge, FIFO sinks and a handshake monitor
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0; tx_n <= 0; rx_rd <= 0; hs_cnt <= 0;
      viol <= 0; prev_pend <= 1'b0; prev_addr <= '0;
    end else begin
      if (mem_req && !mem_ack) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[8:2]];
      end else begin
        mem_ack <= 1'b0;
      end
      if (mem_req && mem_ack && mem_we) mem[mem_addr[8:2]] <= mem_wdata;
      if (prev_pend && (!mem_req || mem_addr != prev_addr)) viol <= viol + 1;
      prev_pend <= mem_req && !mem_ack;
      prev_addr <= mem_addr;
      if (tb_clr) begin
        tx_n <= 0; rx_rd <= 0; hs_cnt <= 0;
      end else begin
        if (mem_req && mem_ack) hs_cnt <= hs_cnt + 1;
        if (fifo_push) begin txq[tx_n[5:0]] <= fifo_wdata; tx_n <= tx_n + 1; end
        if (fifo_pop) rx_rd <= rx_rd + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic clr_pulse();
    @(negedge clk); tb_clr = 1'b1;
    @(negedge clk); tb_clr = 1'b0;
  endtask

  task automatic wait_stat(input int maxc, output logic [31:0] s);
    s = '0;
    for (int i = 0; i < maxc; i++) begin
      rd(2'd3, s);
      if (s != 0) break;
    end
  endtask

  task automatic build(input bit dir, input bit chain, input int nd, input int c0, input int c1,
                       input logic [31:0] own0);
    clr_pulse();
    for (int i = 0; i < 128; i++) mem[i] = '0;
    for (int i = 0; i < 8; i++) begin
      if (dir) begin
        mem[64+i] = 32'hA000_0000 + i;
        mem[96+i] = 32'hB000_0000 + i;
      end
    end
    for (int i = 0; i < 64; i++) rx_src[i] = 32'h5000_0000 + i;
    f0 = own0 | FS | (chain ? CH : 32'h0) | ((nd == 1) ? LD : 32'h0) | 32'h0000_0100;
    mem[0] = f0; mem[1] = c0; mem[2] = 32'd256; mem[3] = 32'd48;
    d1w = chain ? 12 : 4;
    f1 = OWN | (chain ? CH : 32'h0) | LD;
    if (nd == 2) begin
      mem[d1w] = f1; mem[d1w+1] = c1; mem[d1w+2] = 32'd384; mem[d1w+3] = 32'd0;
    end
  endtask

  task automatic go(input bit dir, input logic [31:0] ctrl_extra);
    wr(2'd0, RUN | (dir ? TXB : 32'h0) | ctrl_extra);
    wr(2'd1, 32'h80);
    wr(2'd2, 32'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] s, v;
    int bad, w0;
    rx_avail = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state, R10
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk(v == 0, "R10 register reads zero after reset", v, 0);
    end
    chk(mem_req == 1'b0 && fifo_flush == 1'b0, "R10 idle outputs after reset", {mem_req, fifo_flush}, 0);

    // table of transfers
    for (int k = 0; k < NVEC; k++) begin
      logic [27:0] e;
      bit dir, chain;
      int nd, c0, c1, ew;
      e = VEC[k];
      dir = e[27]; chain = e[26]; nd = e[25:24]; c0 = e[23:16]; c1 = e[15:8]; ew = e[7:0];
      w0 = (c0 + 3) / 4;
      build(dir, chain, nd, c0, c1, OWN);
      rx_avail = 64;
      go(dir, 32'h0);
      wait_stat(600, s);
      chk(s == 32'd1, "R8 R1 walk ends with completion status", s, 1);
      chk(mem[0] == (f0 & ~OWN), "R6 first descriptor handed back", mem[0], f0 & ~OWN);
      if (nd == 2)
        chk(mem[d1w] == (f1 & ~OWN), "R7 second descriptor located and handed back", mem[d1w], f1 & ~OWN);
      bad = 0;
      if (dir) begin
        chk(tx_n == ew, "R4 words pushed on transmit", tx_n, ew);
        for (int i = 0; i < ew; i++)
          if (txq[i] != ((i < w0) ? 32'hA000_0000 + i : 32'hB000_0000 + (i - w0))) bad++;
      end else begin
        chk(rx_rd == ew, "R4 words popped on receive", rx_rd, ew);
        for (int i = 0; i < ew; i++)
          if (((i < w0) ? mem[64+i] : mem[96+i-w0]) != rx_src[i]) bad++;
        chk(mem[64+w0] == 0, "R4 receive stops at rounded count", mem[64+w0], 0);
      end
      chk(bad == 0, "R4 data order", bad, 0);
      wr(2'd3, 32'h3);
      rd(2'd3, v);
      chk(v == 0, "R10 status write-one-to-clear", v, 0);
    end

    // R2: engine stays silent without control bit 25, then starts once it is set
    build(1'b1, 1'b1, 1, 8, 0, OWN);
    wr(2'd0, 32'h20 | TXB);
    wr(2'd1, 32'h80);
    wr(2'd2, 32'h0);
    repeat (40) @(negedge clk);
    chk(hs_cnt == 0, "R2 no memory access without both enables", hs_cnt, 0);
    wr(2'd0, RUN | TXB);
    wait_stat(300, s);
    chk(s == 32'd1 && tx_n == 2, "R2 armed walk starts once enabled", {s[15:0], tx_n[15:0]}, 32'h0001_0002);
    wr(2'd3, 32'h3);

    // R3: descriptor not owned
    build(1'b1, 1'b1, 1, 8, 0, 32'h0);
    go(1'b1, 32'h0);
    wait_stat(300, s);
    repeat (10) @(negedge clk);
    chk(s == 32'd2, "R3 unowned descriptor status", s, 2);
    chk(hs_cnt == 1 && tx_n == 0, "R3 single fetch and no data", {hs_cnt[15:0], tx_n[15:0]}, 32'h0001_0000);
    chk(mem[0] == f0, "R3 unowned descriptor left untouched", mem[0], f0);
    wr(2'd3, 32'h3);

    // R4: zero byte count
    build(1'b1, 1'b1, 1, 0, 0, OWN);
    go(1'b1, 32'h0);
    wait_stat(300, s);
    chk(s == 32'd1 && tx_n == 0, "R4 zero count moves nothing", {s[15:0], tx_n[15:0]}, 32'h0001_0000);
    chk(hs_cnt == 5, "R4 R6 zero count: fetch then write-back only", hs_cnt, 5);
    wr(2'd3, 32'h3);

    // R5: transmit waits while full
    build(1'b1, 1'b1, 1, 8, 0, OWN);
    force_full = 1'b1;
    go(1'b1, 32'h0);
    repeat (60) @(negedge clk);
    rd(2'd3, s);
    chk(tx_n == 0 && s == 0, "R5 no push while FIFO full", {s[15:0], tx_n[15:0]}, 0);
    force_full = 1'b0;
    wait_stat(300, s);
    chk(s == 32'd1 && tx_n == 2 && txq[1] == 32'hA000_0001, "R5 transmit resumes after full clears",
        txq[1], 32'hA000_0001);
    wr(2'd3, 32'h3);

    // R5: receive waits while empty
    build(1'b0, 1'b1, 1, 4, 0, OWN);
    rx_avail = 0;
    go(1'b0, 32'h0);
    repeat (60) @(negedge clk);
    rd(2'd3, s);
    chk(mem[64] == 0 && s == 0, "R5 no pop while FIFO empty", mem[64], 0);
    rx_avail = 1;
    wait_stat(300, s);
    chk(s == 32'd1 && mem[64] == rx_src[0], "R5 receive resumes after data arrives", mem[64], rx_src[0]);
    wr(2'd3, 32'h3);

    // R9: self-clearing FIFO reset bit drives the flush output for one cycle
    wr(2'd0, RUN | 32'h2);
    reg_addr = 2'd0; #1;
    chk(reg_rdata[1] == 1'b1 && fifo_flush == 1'b1, "R9 FIFO reset bit set and flushing",
        {reg_rdata[1], fifo_flush}, 32'h3);
    @(negedge clk); #1;
    chk(reg_rdata[1] == 1'b0 && fifo_flush == 1'b0 && reg_rdata[25] == 1'b1, "R9 FIFO reset bit self-clears",
        reg_rdata, RUN);

    // R9: DMA reset aborts a stalled walk
    build(1'b1, 1'b1, 1, 8, 0, OWN);
    force_full = 1'b1;
    go(1'b1, 32'h0);
    repeat (20) @(negedge clk);
    wr(2'd0, RUN | TXB | 32'h4);
    repeat (5) @(negedge clk);
    force_full = 1'b0;
    repeat (50) @(negedge clk);
    rd(2'd3, s);
    chk(hs_cnt == 4 && tx_n == 0 && s == 0, "R9 DMA reset aborts walk", {hs_cnt[15:0], tx_n[15:0]}, 32'h0004_0000);

    // R9: controller reset clears every register
    wr(2'd2, 32'h40);
    wr(2'd0, 32'h1);
    @(negedge clk);
    rd(2'd2, v);
    chk(v == 0, "R9 controller reset clears base", v, 0);
    rd(2'd0, v);
    chk(v == 0, "R9 controller reset clears control", v, 0);

    // R11: request held until acknowledged across every run
    chk(viol == 0, "R11 request stable until acknowledge", viol, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule